// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a three-phase integrating converter with a 3-1/2 digit reading. It receives the oscillator clock, one comparator bit that tells which side of zero the integrator output sits on, and a synchronous active-low reset. It drives three mutually exclusive switch enables (auto-zero, signal integrate, reference integrate) and a reference-sign select. The clock is prescaled into counts. Every measurement cycle lasts a fixed number of counts, and the signal phase lasts a fixed number of counts inside it. The reference phase is timed in four cascaded BCD decades.

When the reference phase ends, the decade count, the input sign and an overrange flag move into an output latch, and a single-clock valid strobe marks the update. The reference phase ends either when the comparator leaves the polarity captured at the end of signal integration, or when the full-scale limit is reached. Whatever reference time goes unused is added to the following auto-zero phase, so the cycle length never depends on the input.

Top module: `dsc_sequencer`

## Requirements
- R1: While reset is low, and after it, the block is in auto-zero: `az_en_o`=1, `si_en_o`=0, `ri_en_o`=0, `valid_o`=0, and `digit_o`, `neg_o` and `over_o` are all 0. The first auto-zero after reset lasts 1000 counts.
- R2: Exactly one of `az_en_o`, `si_en_o` and `ri_en_o` is high in every clock.
- R3: One count is PRESCALE clocks, and phase changes happen only on count boundaries. The signal phase always lasts exactly 1000 counts.
- R4: A full cycle (signal, reference, auto-zero) lasts 4000 counts (16000 clocks with PRESCALE=4) for any comparator behaviour.
- R5: At the last count of the signal phase, the comparator value is captured as the polarity (1 = positive). `ref_neg_o` equals the captured polarity for the whole reference phase, and `neg_o` is latched as its inverse.
- R6: In the reference phase, each count on which the comparator still matches the captured polarity advances the decades by one. On the first count where it differs, the phase ends (N counted matches give a phase of N+1 counts) and the decades are latched as the reading. `digit_o[3:0]` holds units, `[7:4]` tens, `[11:8]` hundreds and `[15:12]` thousands, each digit in BCD (0..9).
- R7: If the comparator still matches after 1999 counted matches, the reference phase ends at its 2000th count with `over_o`=1 and the reading latched as 2000.
- R8: Auto-zero lasts 3000 counts minus the length of the preceding reference phase, so it is never shorter than 1000 counts.
- R9: `digit_o`, `neg_o` and `over_o` change only in the clock where `valid_o` is high, and `valid_o` is never high for two clocks in a row.
- R10: The comparator is ignored during auto-zero and during the signal phase except at its final count. Toggling it there does not change the reading or produce a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_i | input | 1 | Comparator: 1 = integrator on the positive-input side of zero |
| az_en_o | output | 1 | Auto-zero switch enable |
| si_en_o | output | 1 | Signal-integrate switch enable |
| ri_en_o | output | 1 | Reference-integrate switch enable |
| ref_neg_o | output | 1 | 1 selects the negative reference during reference integration |
| digit_o | output | 4*DIGITS | Latched BCD reading, units in the low nibble |
| neg_o | output | 1 | Latched sign, 1 = negative input |
| over_o | output | 1 | Latched overrange flag |
| valid_o | output | 1 | One-clock strobe on each latch update |

## Verification
The hardest case to reach from the ports is the boundary between a full-scale reading and overrange. A crossing on the very last count must still latch 1999 with no flag, while a missing crossing must latch 2000 with the flag set. The bench watches the phase enables and holds the comparator at the captured polarity for an exact number of counts before flipping it, so it can place the crossing on any count, including the final one. The same comparator model produces the shortest reference phase and the longest one, and the auto-zero length that follows each of them is measured.

// File: rtl/dsc_pkg.sv
// Package: shared types and constant helpers for the dual-slope sequencer.
// Assumes: readings fit in at most 16 BCD digits.
package dsc_pkg;

    // Switch phase of the measurement cycle.
    typedef enum logic [1:0] {
        PH_AZ = 2'd0,
        PH_SI = 2'd1,
        PH_RI = 2'd2
    } phase_t;

    // Convert a binary constant to packed BCD, units in the low nibble.
    function automatic logic [63:0] bin_to_bcd(input int unsigned val, input int unsigned ndig);
        logic [63:0]  r;
        int unsigned  v;
        r = '0;
        v = val;
        for (int i = 0; i < 16; i++) begin
            if (i < ndig) r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dsc_prescaler.sv
// Module: count-tick generator. Produces a one-clock tick every PRESCALE clocks.
// Assumes: PRESCALE >= 1; a value of 1 ticks on every clock.
module dsc_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_q;

    // Divide the oscillator clock down to count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/dsc_bcd_counter.sv
// Module: cascaded BCD decade counter with synchronous clear.
// Assumes: clear has priority over increment; it wraps silently past all nines.
module dsc_bcd_counter #(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [4*NDIG-1:0] value_o
);
    logic [NDIG-1:0] carry;

    assign carry[0] = inc_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dec
        logic [3:0] d_q;

        // Advance this decade when every lower decade rolls over.
        always_ff @(posedge clk) begin
            if (!rst_n)          d_q <= 4'd0;
            else if (clr_i)      d_q <= 4'd0;
            else if (carry[g])   d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
        end

        if (g < NDIG - 1) begin : g_carry
            assign carry[g+1] = carry[g] && (d_q == 4'd9);
        end

        assign value_o[4*g +: 4] = d_q;

        // R6
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            d_q <= 4'd9);
    end

endmodule

// File: rtl/dsc_phase_ctrl.sv
// Module: cycle timer and phase state machine.
// The timer runs 0..CYCLE_COUNTS-1 on every count. The signal phase starts when it
// wraps, and the reference phase starts after SI_COUNTS. The reference phase ends on
// a comparator change or when the limit is reached; auto-zero fills the remainder.
// Assumes: CYCLE_COUNTS > SI_COUNTS + MAX_DEINT.
module dsc_phase_ctrl
    import dsc_pkg::*;
#(
    parameter int SI_COUNTS    = 1000,
    parameter int MAX_DEINT    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int NDIG         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              comp_i,
    input  logic [4*NDIG-1:0] count_i,
    output phase_t            phase_o,
    output logic              pol_o,
    output logic              clr_o,
    output logic              inc_o,
    output logic              done_o,
    output logic              over_o
);
    localparam int BW = 4 * NDIG;
    localparam int TW = $clog2(CYCLE_COUNTS);
    localparam logic [TW-1:0] T_WRAP = TW'(CYCLE_COUNTS - 1);
    localparam logic [TW-1:0] T_SI_END = TW'(SI_COUNTS - 1);
    localparam logic [TW-1:0] T_RST = TW'(SI_COUNTS + MAX_DEINT);
    localparam logic [TW-1:0] T_RI_LIM = TW'(SI_COUNTS + MAX_DEINT);
    localparam logic [63:0] LAST_FULL = bin_to_bcd(MAX_DEINT - 1, NDIG);
    localparam logic [BW-1:0] LAST_BCD = LAST_FULL[BW-1:0];

    phase_t        phase_q;
    logic [TW-1:0] t_q;
    logic          pol_q;

    // Decide counter actions and the end of the reference phase on each tick.
    always_comb begin
        clr_o  = 1'b0;
        inc_o  = 1'b0;
        done_o = 1'b0;
        over_o = 1'b0;
        if (tick_i) begin
            case (phase_q)
                PH_SI: clr_o = (t_q == T_SI_END);
                PH_RI: begin
                    if (comp_i != pol_q) begin
                        done_o = 1'b1;
                    end else if (count_i == LAST_BCD) begin
                        done_o = 1'b1;
                        over_o = 1'b1;
                    end else begin
                        inc_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Free-running cycle timer, one step per count.
    always_ff @(posedge clk) begin
        if (!rst_n)       t_q <= T_RST;
        else if (tick_i)  t_q <= (t_q == T_WRAP) ? '0 : t_q + 1'b1;
    end

    // Phase sequencing and polarity capture at the end of signal integration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_AZ;
            pol_q   <= 1'b0;
        end else if (tick_i) begin
            case (phase_q)
                PH_AZ: if (t_q == T_WRAP) phase_q <= PH_SI;
                PH_SI: if (t_q == T_SI_END) begin
                    phase_q <= PH_RI;
                    pol_q   <= comp_i;
                end
                PH_RI: if (done_o) phase_q <= PH_AZ;
                default: phase_q <= PH_AZ;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign pol_o   = pol_q;

    // R3
    phase_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(phase_q));

    // R7
    ri_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RI) |-> (t_q >= TW'(SI_COUNTS) && t_q < T_RI_LIM));

    // R4
    wrap_starts_si_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && t_q == T_WRAP) |=> (phase_q == PH_SI));

    // R5
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RI && $past(phase_q) == PH_RI) |-> $stable(pol_q));

endmodule

// File: rtl/dsc_result_latch.sv
// Module: output latch for the reading, sign and overrange, with a valid strobe.
// Assumes: load is a single-clock pulse.
module dsc_result_latch #(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [4*NDIG-1:0] digits_i,
    input  logic              neg_i,
    input  logic              over_i,
    output logic [4*NDIG-1:0] digits_o,
    output logic              neg_o,
    output logic              over_o,
    output logic              valid_o
);
    // Capture the result at the end of reference integration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits_o <= '0;
            neg_o    <= 1'b0;
            over_o   <= 1'b0;
        end else if (load_i) begin
            digits_o <= digits_i;
            neg_o    <= neg_i;
            over_o   <= over_i;
        end
    end

    // Strobe that follows each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= load_i;
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(digits_o) && $stable(neg_o) && $stable(over_o)));

    // R9
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/dsc_sequencer.sv
// Module: top of the dual-slope conversion phase sequencer.
// Connects the prescaler, phase controller, BCD decades and result latch, and
// decodes the phase into one-hot switch enables.
// Assumes: the comparator is synchronous to clk.
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int PRESCALE     = 4,
    parameter int SI_COUNTS    = 1000,
    parameter int MAX_DEINT    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int DIGITS       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                comp_i,
    output logic                az_en_o,
    output logic                si_en_o,
    output logic                ri_en_o,
    output logic                ref_neg_o,
    output logic [4*DIGITS-1:0] digit_o,
    output logic                neg_o,
    output logic                over_o,
    output logic                valid_o
);
    localparam int BW = 4 * DIGITS;
    localparam logic [63:0] OVR_FULL = bin_to_bcd(MAX_DEINT, DIGITS);
    localparam logic [BW-1:0] OVR_BCD = OVR_FULL[BW-1:0];

    logic          tick;
    logic [BW-1:0] count;
    phase_t        phase;
    logic          pol, clr, inc, done, over;
    logic [BW-1:0] result;

    dsc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    dsc_phase_ctrl #(
        .SI_COUNTS    (SI_COUNTS),
        .MAX_DEINT    (MAX_DEINT),
        .CYCLE_COUNTS (CYCLE_COUNTS),
        .NDIG         (DIGITS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .comp_i  (comp_i),
        .count_i (count),
        .phase_o (phase),
        .pol_o   (pol),
        .clr_o   (clr),
        .inc_o   (inc),
        .done_o  (done),
        .over_o  (over)
    );

    dsc_bcd_counter #(.NDIG(DIGITS)) u_bcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .inc_i   (inc),
        .value_o (count)
    );

    // Overrange reports the limit value instead of the last decade state.
    assign result = over ? OVR_BCD : count;

    dsc_result_latch #(.NDIG(DIGITS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (done),
        .digits_i (result),
        .neg_i    (~pol),
        .over_i   (over),
        .digits_o (digit_o),
        .neg_o    (neg_o),
        .over_o   (over_o),
        .valid_o  (valid_o)
    );

    assign az_en_o   = (phase == PH_AZ);
    assign si_en_o   = (phase == PH_SI);
    assign ri_en_o   = (phase == PH_RI);
    assign ref_neg_o = pol;

    // R2
    one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({az_en_o, si_en_o, ri_en_o}) == 1);

    // R6
    strobe_after_ri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(ri_en_o) && az_en_o));

endmodule

// File: tb/dsc_sequencer_tb.sv
// Bench: walks a table of (polarity, comparator delay, noise) vectors through the
// sequencer, then directed tests for reset and the PRESCALE=4 cycle timing.
module dsc_sequencer_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comp = 1'b0;
    logic comp4 = 1'b1;

    logic        az, si, ri, rneg, neg, over, valid;
    logic [15:0] dig;
    logic        az4, si4, ri4, rneg4, neg4, over4, valid4;
    logic [15:0] dig4;

    always #4 clk = ~clk;

    dsc_sequencer #(.PRESCALE(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .comp_i(comp),
        .az_en_o(az), .si_en_o(si), .ri_en_o(ri), .ref_neg_o(rneg),
        .digit_o(dig), .neg_o(neg), .over_o(over), .valid_o(valid)
    );

    dsc_sequencer u_dut_p4 (
        .clk(clk), .rst_n(rst_n), .comp_i(comp4),
        .az_en_o(az4), .si_en_o(si4), .ri_en_o(ri4), .ref_neg_o(rneg4),
        .digit_o(dig4), .neg_o(neg4), .over_o(over4), .valid_o(valid4)
    );

    int checks = 0;
    int fails = 0;
    int prev_ri = 2000;
    int stab_bad = 0;
    int hot_bad = 0;
    int cyc = 0;
    logic [15:0] prev_dig = '0;
    logic prev_neg = 1'b0, prev_over = 1'b0, prev_valid = 1'b0;

    localparam int NV = 11;
    localparam bit VPOS[NV]   = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
    localparam int VCNT[NV]   = '{0, 0, 1, 9, 10, 999, 1000, 1234, 1999, 2000, 2600};
    localparam bit VNOISE[NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] bcd4(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    // Output stability, strobe width, one-hot enables and watchdog.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!valid && (dig != prev_dig || neg != prev_neg || over != prev_over)) stab_bad++;
            if (valid && prev_valid) stab_bad++;
            if ($countones({az, si, ri}) != 1) hot_bad++;
        end
        prev_dig = dig; prev_neg = neg; prev_over = over; prev_valid = valid;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // One conversion, entered at a negedge in auto-zero.
    task automatic run_conv(input bit pos, input int n, input bit noisy);
        int  azc = 0;
        int  sic = 0;
        int  k = 0;
        bit  ov = (n >= 2000);
        int  exp_ri = ov ? 2000 : n + 1;
        while (az) begin
            if (noisy) comp = ~comp;
            azc++;
            @(negedge clk);
        end
        chk(azc == 3000 - prev_ri, "R8 auto-zero length", azc, 3000 - prev_ri);
        while (si) begin
            comp = (noisy && sic < 500) ? ~comp : pos;
            sic++;
            @(negedge clk);
        end
        chk(sic == 1000, "R3 signal phase length", sic, 1000);
        chk(ri && rneg == pos, "R5 reference select", int'(rneg), int'(pos));
        while (!valid && k < 2100) begin
            if (k == n) comp = ~pos;
            @(negedge clk);
            k++;
        end
        chk(k == exp_ri, "R6 reference phase length", k, exp_ri);
        chk(dig == bcd4(ov ? 2000 : n), noisy ? "R10 reading under noise" : "R6 reading",
            int'(dig), int'(bcd4(ov ? 2000 : n)));
        chk(neg == !pos, "R5 sign", int'(neg), int'(!pos));
        chk(over == ov, "R7 overrange flag", int'(over), int'(ov));
        prev_ri = exp_ri;
    endtask

    initial begin
        int c4;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(az && !si && !ri, "R1 reset phase", int'({az, si, ri}), 4);
        chk(dig == 16'h0 && !neg && !over && !valid, "R1 reset outputs", int'(dig), 0);
        rst_n = 1'b1;
        prev_ri = 2000;

        for (int i = 0; i < NV; i++) run_conv(VPOS[i], VCNT[i], VNOISE[i]);

        // R1 reset in the middle of reference integration
        while (!ri) @(negedge clk);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(az && !si && !ri && !valid, "R1 mid-run reset phase", int'({az, si, ri}), 4);
        chk(dig == 16'h0 && !neg && !over, "R1 mid-run reset outputs", int'(dig), 0);
        rst_n = 1'b1;
        prev_ri = 2000;
        run_conv(1'b1, 5, 1'b0);

        // R3 R4 R7 prescaled instance, comparator never crosses
        while (!az4) @(negedge clk);
        while (az4) @(negedge clk);
        c4 = 0;
        while (si4) begin c4++; @(negedge clk); end
        chk(c4 == 4000, "R3 prescaled signal phase", c4, 4000);
        c4 = 0;
        while (ri4) begin c4++; @(negedge clk); end
        chk(c4 == 8000, "R7 prescaled reference limit", c4, 8000);
        chk(dig4 == 16'h2000 && over4 && !neg4, "R7 prescaled overrange", int'(dig4), 'h2000);
        c4 = 0;
        while (az4) begin c4++; @(negedge clk); end
        chk(c4 == 4000, "R4 prescaled cycle remainder", c4, 4000);

        chk(stab_bad == 0, "R9 output stability", stab_bad, 0);
        chk(hot_bad == 0, "R2 one-hot enables", hot_bad, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule